// File: doc/BRIEF.md
# Power-Management Interrupt and Wake Controller

This block collects energy-detect and wake-on-LAN indications from two PHY ports and turns them into a small set of sticky, software-visible status bits. Each port contributes a per-port wake status. That status is qualified by a per-port enable and merged into a single power-management-event status, held in an interrupt status register. The event status is latched whether or not its interrupt enable is on, so software can poll it.

The qualified event status is merged with the chip's other interrupt sources, gated by a master interrupt enable and driven out on an IRQ pin of selectable polarity. Separately, a wake-up output follows the event status while a wake bit is set. The same register space holds a switch-disable bit that is guarded against accidental writes: it takes effect only when it is written as 1 on two consecutive writes to its register.

Software reaches the block through a simple synchronous register bus with address, write data, a write strobe and combinational read data. There are four registers: power control at address 0, interrupt status at 1, interrupt enable at 2 and IRQ configuration at 3.

Top module: `pmWakeCtrl`

## Requirements
- R1: A port's wake status sets on the clock edge that sees any bit of (PHY source AND PHY mask) high for that port. Source and mask are 2 bits each: bit 0 stands for PHY source bit 7 and bit 1 for PHY source bit 8. A source bit whose mask bit is 0 never sets the status.
- R2: Port A's wake status reads at bit 16 and port B's at bit 17 of address 0. Both stay set after the source goes away.
- R3: Writing 1 to bit 16 or bit 17 of address 0 clears that port's status. The clear has no effect while that port's masked source is still active, and writing 0 to those bits changes nothing.
- R4: The event status at bit 17 of address 1 sets one edge after (port A status AND enable bit 14 of address 0) OR (port B status AND enable bit 15) is true. It sets whatever the value of the event interrupt enable at bit 17 of address 2. It is sticky and is cleared by writing 1 to bit 17 of address 1, unless its set condition is still true.
- R5: The internal request is true when master enable bit 8 of address 3 is 1 and either (event status AND event interrupt enable) is true or any otherIrq bit is high. irqPin equals the request when polarity bit 0 of address 3 is 1, and its inverse when that bit is 0 (active-low).
- R6: wakeOut is high exactly while the event status is set and wake bit 28 of address 0 is 1.
- R7: The switch-disable bit (bit 0 of address 0) becomes 1 only on the second of two consecutive writes to address 0 with bit 0 = 1. A write to address 0 with bit 0 = 0 clears both the bit and the pending confirmation. Writes to other addresses do not break the sequence.
- R8: After reset every register reads 0, wakeOut is 0 and irqPin is 1 (inactive, active-low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regWrEn | input | 1 | Write strobe, one write per cycle it is high |
| regRdData | output | 32 | Combinational read data for regAddr |
| phySrcA | input | 2 | Port A PHY event sources (bit 0 = source 7, bit 1 = source 8) |
| phyMaskA | input | 2 | Port A PHY mask bits, same layout |
| phySrcB | input | 2 | Port B PHY event sources |
| phyMaskB | input | 2 | Port B PHY mask bits |
| otherIrq | input | 4 | Other interrupt requests, already qualified, level |
| irqPin | output | 1 | Interrupt request pin, polarity per configuration |
| wakeOut | output | 1 | Wake-up request, active high |

## Verification
A register write is visible on read data and on the configuration-driven outputs right after the edge that captures it. A masked PHY event shows in the port status one edge after it is applied and in the event status, irqPin and wakeOut two edges after. irqPin and wakeOut are combinational from registers, so they move in the same cycle as the event status. The bench drives every input on a falling edge and samples on a later falling edge, after exactly the number of rising edges each result needs. This places every comparison half a cycle away from any edge where the value could change.

// File: rtl/pmWakePkg.sv
`timescale 1ns/1ps
package pmWakePkg;
  localparam int NUM_PORTS    = 2;
  // field positions, decoded by software
  localparam int PORT_EN_LSB  = 14;
  localparam int PORT_STS_LSB = 16;
  localparam int WAKE_BIT     = 28;
  localparam int SWDIS_BIT    = 0;
  localparam int PME_BIT      = 17;
  localparam int MASTER_BIT   = 8;
  localparam int POL_BIT      = 0;
  // register addresses
  localparam int ADDR_PMCTL   = 0;
  localparam int ADDR_INTSTS  = 1;
  localparam int ADDR_INTEN   = 2;
  localparam int ADDR_IRQCFG  = 3;

  typedef struct packed {
    logic                 wrPmCtl;
    logic                 wrIntSts;
    logic                 wrIntEn;
    logic                 wrIrqCfg;
    logic [NUM_PORTS-1:0] portEn;
    logic [NUM_PORTS-1:0] portClr;
    logic                 wakeEn;
    logic                 pmeClr;
    logic                 pmeEn;
    logic                 masterEn;
    logic                 polHigh;
    logic                 setDis;
    logic                 clrDis;
  } pmStrobeT;
endpackage

// File: rtl/pmWakeCtl.sv
`timescale 1ns/1ps
module pmWakeCtl
  import pmWakePkg::*;
#(
  parameter int ADDR_W         = 2,
  parameter int DATA_W         = 32,
  parameter int CONFIRM_WRITES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output pmStrobeT          strobe
);
  localparam int CNT_W = $clog2(CONFIRM_WRITES + 1);

  logic [CNT_W-1:0] confirmCnt;
  logic             unusedData;

  assign unusedData = ^regWrData;

  always_comb begin
    strobe          = '0;
    strobe.wrPmCtl  = regWrEn && (regAddr == ADDR_W'(ADDR_PMCTL));
    strobe.wrIntSts = regWrEn && (regAddr == ADDR_W'(ADDR_INTSTS));
    strobe.wrIntEn  = regWrEn && (regAddr == ADDR_W'(ADDR_INTEN));
    strobe.wrIrqCfg = regWrEn && (regAddr == ADDR_W'(ADDR_IRQCFG));
    for (int p = 0; p < NUM_PORTS; p++) begin
      strobe.portEn[p]  = regWrData[PORT_EN_LSB + p];
      strobe.portClr[p] = strobe.wrPmCtl && regWrData[PORT_STS_LSB + p];
    end
    strobe.wakeEn   = regWrData[WAKE_BIT];
    strobe.pmeClr   = strobe.wrIntSts && regWrData[PME_BIT];
    strobe.pmeEn    = regWrData[PME_BIT];
    strobe.masterEn = regWrData[MASTER_BIT];
    strobe.polHigh  = regWrData[POL_BIT];
    if (strobe.wrPmCtl) begin
      if (regWrData[SWDIS_BIT]) begin
        strobe.setDis = (confirmCnt == CNT_W'(CONFIRM_WRITES - 1));
      end else begin
        strobe.clrDis = 1'b1;
      end
    end
  end

  // count confirming writes of 1; a 0 or a completed sequence restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      confirmCnt <= '0;
    end else if (strobe.wrPmCtl) begin
      if (!regWrData[SWDIS_BIT] || strobe.setDis) confirmCnt <= '0;
      else                                        confirmCnt <= confirmCnt + CNT_W'(1);
    end
  end

  // R7
  zero_resets_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrPmCtl && !regWrData[SWDIS_BIT]) |=> (confirmCnt == '0));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    confirmCnt <= CNT_W'(CONFIRM_WRITES - 1));
endmodule

// File: rtl/pmWakeDp.sv
`timescale 1ns/1ps
module pmWakeDp
  import pmWakePkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 32,
  parameter int EVT_W     = 2,
  parameter int NUM_OTHER = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  pmStrobeT                            strobe,
  input  logic [ADDR_W-1:0]                   regAddr,
  input  logic [NUM_PORTS-1:0][EVT_W-1:0]     portSrc,
  input  logic [NUM_PORTS-1:0][EVT_W-1:0]     portMask,
  input  logic [NUM_OTHER-1:0]                otherIrq,
  output logic [DATA_W-1:0]                   regRdData,
  output logic                                irqPin,
  output logic                                wakeOut
);
  logic [NUM_PORTS-1:0] portEvt;
  logic [NUM_PORTS-1:0] portSts;
  logic [NUM_PORTS-1:0] portEn;
  logic                 wakeEn;
  logic                 switchDis;
  logic                 pmeSts;
  logic                 pmeEn;
  logic                 masterEn;
  logic                 polHigh;
  logic                 pmeSet;
  logic                 irqActive;
  logic                 unusedStrobe;

  assign unusedStrobe = strobe.wrIntSts;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    logic stsQ;
    assign portEvt[p] = |(portSrc[p] & portMask[p]);
    // level source wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stsQ <= 1'b0;
      else       stsQ <= portEvt[p] | (stsQ & ~strobe.portClr[p]);
    end
    assign portSts[p] = stsQ;

    // R1
    evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rstN)
      portEvt[p] |=> stsQ);
    // R2
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stsQ && !strobe.portClr[p]) |=> stsQ);
    // R3
    sts_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.portClr[p] && !portEvt[p]) |=> !stsQ);
  end

  assign pmeSet = |(portSts & portEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmeSts    <= 1'b0;
      portEn    <= '0;
      wakeEn    <= 1'b0;
      switchDis <= 1'b0;
      pmeEn     <= 1'b0;
      masterEn  <= 1'b0;
      polHigh   <= 1'b0;
    end else begin
      pmeSts <= pmeSet | (pmeSts & ~strobe.pmeClr);
      if (strobe.wrPmCtl) begin
        portEn <= strobe.portEn;
        wakeEn <= strobe.wakeEn;
      end
      if (strobe.setDis)      switchDis <= 1'b1;
      else if (strobe.clrDis) switchDis <= 1'b0;
      if (strobe.wrIntEn) pmeEn <= strobe.pmeEn;
      if (strobe.wrIrqCfg) begin
        masterEn <= strobe.masterEn;
        polHigh  <= strobe.polHigh;
      end
    end
  end

  assign irqActive = masterEn & ((pmeSts & pmeEn) | (|otherIrq));
  assign irqPin    = polHigh ? irqActive : ~irqActive;
  assign wakeOut   = wakeEn & pmeSts;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_PMCTL): begin
        regRdData[PORT_EN_LSB +: NUM_PORTS]  = portEn;
        regRdData[PORT_STS_LSB +: NUM_PORTS] = portSts;
        regRdData[WAKE_BIT]                  = wakeEn;
        regRdData[SWDIS_BIT]                 = switchDis;
      end
      ADDR_W'(ADDR_INTSTS): regRdData[PME_BIT] = pmeSts;
      ADDR_W'(ADDR_INTEN):  regRdData[PME_BIT] = pmeEn;
      ADDR_W'(ADDR_IRQCFG): begin
        regRdData[MASTER_BIT] = masterEn;
        regRdData[POL_BIT]    = polHigh;
      end
      default: regRdData = '0;
    endcase
  end

  // R4
  pme_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    pmeSet |=> pmeSts);
  // R5
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrIrqCfg && !strobe.masterEn) |=> (irqPin == !polHigh));
  // R6
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pmeSet && wakeEn && !strobe.wrPmCtl) |=> wakeOut);
  // R7
  dis_rose_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(switchDis) |-> $past(strobe.setDis));
endmodule

// File: rtl/pmWakeCtrl.sv
`timescale 1ns/1ps
module pmWakeCtrl
  import pmWakePkg::*;
#(
  parameter int ADDR_W         = 2,
  parameter int DATA_W         = 32,
  parameter int EVT_W          = 2,
  parameter int NUM_OTHER      = 4,
  parameter int CONFIRM_WRITES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 regWrEn,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [EVT_W-1:0]     phySrcA,
  input  logic [EVT_W-1:0]     phyMaskA,
  input  logic [EVT_W-1:0]     phySrcB,
  input  logic [EVT_W-1:0]     phyMaskB,
  input  logic [NUM_OTHER-1:0] otherIrq,
  output logic                 irqPin,
  output logic                 wakeOut
);
  pmStrobeT                        strobe;
  logic [NUM_PORTS-1:0][EVT_W-1:0] portSrc;
  logic [NUM_PORTS-1:0][EVT_W-1:0] portMask;

  assign portSrc  = {phySrcB, phySrcA};
  assign portMask = {phyMaskB, phyMaskA};

  pmWakeCtl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONFIRM_WRITES(CONFIRM_WRITES)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .strobe(strobe)
  );

  pmWakeDp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W), .NUM_OTHER(NUM_OTHER)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .portSrc(portSrc), .portMask(portMask), .otherIrq(otherIrq),
    .regRdData(regRdData), .irqPin(irqPin), .wakeOut(wakeOut)
  );
endmodule

// File: tb/test_pmWakeCtrl.sv
`timescale 1ns/1ps
module test_pmWakeCtrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regRdData;
  logic [1:0]  phySrcA = '0, phyMaskA = '0, phySrcB = '0, phyMaskB = '0;
  logic [3:0]  otherIrq = '0;
  logic        irqPin, wakeOut;
  int          vecCnt = 0;
  int          errCnt = 0;

  localparam logic [31:0] STS_A = 32'h1 << 16;
  localparam logic [31:0] STS_B = 32'h1 << 17;
  localparam logic [31:0] EN_A  = 32'h1 << 14;
  localparam logic [31:0] WAKE  = 32'h1 << 28;
  localparam logic [31:0] PME   = 32'h1 << 17;
  localparam logic [31:0] MSTR  = 32'h1 << 8;

  always #2.5 clk = ~clk;

  pmWakeCtrl i_pmWakeCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .phySrcA(phySrcA),
    .phyMaskA(phyMaskA), .phySrcB(phySrcB), .phyMaskB(phyMaskB),
    .otherIrq(otherIrq), .irqPin(irqPin), .wakeOut(wakeOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; phySrcA = '0; phyMaskA = '0; phySrcB = '0; phyMaskB = '0;
    otherIrq = '0; regWrEn = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.5;
    check(req, regRdData, exp);
  endtask

  task automatic tReset();
    doReset();
    wr(2'd0, EN_A | WAKE);
    wr(2'd3, MSTR | 32'h1);
    wr(2'd2, PME);
    doReset();
    for (int a = 0; a < 4; a++) rdChk("R8 reg read", 2'(a), 32'h0);
    check("R8 irqPin", {31'b0, irqPin}, 32'h1);
    check("R8 wakeOut", {31'b0, wakeOut}, 32'h0);
  endtask

  task automatic tPortEvent();
    doReset();
    phyMaskA = 2'b01; phySrcA = 2'b10;       // unmasked source
    tick(2);
    rdChk("R1 unmasked source", 2'd0, 32'h0);
    phySrcA = 2'b01;
    tick(1);
    rdChk("R1 masked source 7 sets A", 2'd0, STS_A);
    phySrcA = 2'b00;
    tick(2);
    rdChk("R2 A sticky", 2'd0, STS_A);
    phyMaskB = 2'b10; phySrcB = 2'b10;
    tick(1);
    phySrcB = 2'b00;
    tick(1);
    rdChk("R1 R2 source 8 sets B", 2'd0, STS_A | STS_B);
  endtask

  task automatic tClear();
    doReset();
    phyMaskA = 2'b11; phySrcA = 2'b01;
    phyMaskB = 2'b11; phySrcB = 2'b10;
    tick(1);
    phySrcA = 2'b00;                          // B source stays active
    wr(2'd0, STS_A | STS_B);
    rdChk("R3 clear A, B held by source", 2'd0, STS_B);
    phySrcB = 2'b00;
    tick(1);
    wr(2'd0, 32'h0);
    rdChk("R3 write 0 no effect", 2'd0, STS_B);
    wr(2'd0, STS_B);
    rdChk("R3 clear B", 2'd0, 32'h0);
  endtask

  task automatic tPme();
    doReset();
    phyMaskA = 2'b01; phySrcA = 2'b01;
    tick(1);
    phySrcA = 2'b00;
    tick(2);
    rdChk("R4 no pme without port enable", 2'd1, 32'h0);
    wr(2'd0, EN_A);
    tick(1);
    rdChk("R4 pme sets with int enable off", 2'd1, PME);
    check("R4 irq stays inactive", {31'b0, irqPin}, 32'h1);
    wr(2'd1, PME);
    rdChk("R4 clear blocked while set condition true", 2'd1, PME);
    wr(2'd0, EN_A | STS_A);
    tick(1);
    wr(2'd1, PME);
    rdChk("R4 pme cleared", 2'd1, 32'h0);
  endtask

  task automatic tIrq();
    doReset();
    wr(2'd0, EN_A);
    wr(2'd2, PME);
    phyMaskA = 2'b10; phySrcA = 2'b10;
    tick(1);
    phySrcA = 2'b00;
    tick(1);
    check("R5 master off keeps pin high", {31'b0, irqPin}, 32'h1);
    wr(2'd3, MSTR);
    check("R5 active-low request", {31'b0, irqPin}, 32'h0);
    wr(2'd3, MSTR | 32'h1);
    check("R5 active-high request", {31'b0, irqPin}, 32'h1);
    wr(2'd2, 32'h0);
    check("R5 int enable off idles pin", {31'b0, irqPin}, 32'h0);
    @(negedge clk); otherIrq = 4'b0100; #0.5;
    check("R5 other source", {31'b0, irqPin}, 32'h1);
    wr(2'd3, 32'h1);
    check("R5 master off idles pin", {31'b0, irqPin}, 32'h0);
  endtask

  task automatic tWake();
    doReset();
    wr(2'd0, EN_A);
    phyMaskA = 2'b01; phySrcA = 2'b01;
    tick(1);
    phySrcA = 2'b00;
    tick(1);
    check("R6 wake bit off", {31'b0, wakeOut}, 32'h0);
    wr(2'd0, EN_A | WAKE);
    check("R6 wake asserted", {31'b0, wakeOut}, 32'h1);
    wr(2'd0, EN_A | WAKE | STS_A);
    tick(1);
    wr(2'd1, PME);
    check("R6 wake drops with pme", {31'b0, wakeOut}, 32'h0);
  endtask

  task automatic tSwitch();
    doReset();
    wr(2'd0, 32'h1);
    rdChk("R7 single write", 2'd0, 32'h0);
    wr(2'd0, 32'h1);
    rdChk("R7 second write sets", 2'd0, 32'h1);
    wr(2'd0, 32'h0);
    rdChk("R7 write 0 clears", 2'd0, 32'h0);
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h1);
    rdChk("R7 zero breaks sequence", 2'd0, 32'h0);
    wr(2'd0, 32'h1);
    rdChk("R7 new pair sets", 2'd0, 32'h1);
    doReset();
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h1);
    rdChk("R7 other address keeps sequence", 2'd0, 32'h1);
  endtask

  initial begin
    tReset();
    tPortEvent();
    tClear();
    tPme();
    tIrq();
    tWake();
    tSwitch();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule